// File: doc/BRIEF.md
# Accumulator Execute and Flag Unit

This unit executes six single-byte accumulator instructions of an 8-bit microcontroller core: shift left of A or B, decrement of A or B, copy of B into A, and the unsigned multiply of A by B into the 16-bit pair D. The core's sequencer presents a decoded opcode with a one-cycle strobe, together with the current A, B and condition-code values. The unit captures these operands, waits the instruction's cycle count, and then writes the new A, B and flag values into its output registers. In the same cycle it raises a one-cycle completion pulse.

Each instruction has its own flag rule. A shift derives overflow from the sign and carry of its result. A decrement flags overflow only when it wraps the most negative operand. A copy clears overflow. A multiply updates carry alone, and takes it from the top bit of the low product byte. Every flag an instruction does not write keeps the value that came in with the operands. The unit also reports, combinationally, the cycle count of whatever opcode is on its input.

Top module: `acc_exec_unit`

## Requirements
- R1: Accepted opcodes are 0x48 (shift A), 0x58 (shift B), 0x4A (decrement A), 0x5A (decrement B), 0x17 (copy B to A) and 0x3D (multiply). A strobe that carries any other value starts nothing: busy stays low, no completion pulse appears and the outputs keep their values.
- R2: A shift moves the chosen accumulator left one place with a zero entering bit 0. C (bit 0) takes the old bit 7, N (bit 3) takes result bit 7, Z (bit 2) is set when the result is zero, and the other accumulator is unchanged.
- R3: After a shift, V (bit 1) equals N XOR C.
- R4: A decrement subtracts one modulo 256 and sets N and Z from the result. V is set only when the operand was 0x80, and C is unchanged.
- R5: Copy B to A writes B into A and leaves B as it was. It sets N and Z from the moved value, clears V and leaves C unchanged.
- R6: Multiply writes the unsigned 16-bit product of A and B to D, with the high byte in A and the low byte in B. C becomes bit 7 of the new B, and N, Z and V are unchanged.
- R7: A strobe accepted at clock edge k causes the write-back and a one-cycle done pulse at edge k+2 for shift, decrement and copy, and at edge k+3 for multiply. The A, B, D and flag outputs change on no other edge.
- R8: A strobe that arrives while an instruction is in progress is ignored. Only the running instruction completes, and its operands are the ones captured when it was accepted.
- R9: Flag bits an instruction does not write, including H (bit 5) and bits 7, 6 and 4, take the values of the condition-code input captured at acceptance.
- R10: While reset is held, and after it, A, B, D, the flags, busy and done are all zero.
- R11: The cycle-count output shows 2 for a shift, decrement or copy opcode on the opcode input, 3 for multiply and 0 for any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle strobe: opcode and operands are valid |
| opcode | input | 8 | Decoded instruction byte |
| acc_a_in | input | 8 | Current accumulator A |
| acc_b_in | input | 8 | Current accumulator B |
| ccr_in | input | 8 | Current condition-code register |
| acc_a_out | output | 8 | Written-back accumulator A |
| acc_b_out | output | 8 | Written-back accumulator B |
| acc_d_out | output | 16 | Pair D, equal to {A, B} |
| ccr_out | output | 8 | Written-back condition codes |
| cycles_out | output | 2 | Cycle count of the opcode on the input |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle completion and write-back pulse |

## Verification
The bench aims at the overflow edges. A shift of 0x40 or 0x81 must set V, but a shift of 0xC0 must not; a unit that copied V from the carry or the sign alone would miss one of these cases. Decrements of 0x80, 0x00 and 0x01 cover the only V case, the wrap to 0xFF and a zero result. A unit that touched C there would lose a carry that came in set. Multiplies of 0xFF by 0xFF and of 0x10 by 0x08 confirm that C tracks bit 7 of the low byte and not bit 7 of the product's high byte. Further stimulus puts a second strobe under a running multiply and presents an undefined opcode; a unit without a busy guard would complete twice or take the wrong operands.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ASLA = 3'd1,
    OP_ASLB = 3'd2,
    OP_DECA = 3'd3,
    OP_DECB = 3'd4,
    OP_TBA  = 3'd5,
    OP_MUL  = 3'd6
  } acc_op_e;

  localparam logic [7:0] OPC_ASLA = 8'h48;
  localparam logic [7:0] OPC_ASLB = 8'h58;
  localparam logic [7:0] OPC_DECA = 8'h4A;
  localparam logic [7:0] OPC_DECB = 8'h5A;
  localparam logic [7:0] OPC_TBA  = 8'h17;
  localparam logic [7:0] OPC_MUL  = 8'h3D;

  localparam int FLAG_H = 5;
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_V = 1;
  localparam int FLAG_C = 0;

  localparam int unsigned CYC_SHORT = 2;
  localparam int unsigned CYC_MUL   = 3;

endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/acc_decode.sv
module acc_decode
  import acc_exec_pkg::*;
#(
  parameter int OPC_W = 8,
  parameter int CNT_W = 2
) (
  input  logic [OPC_W-1:0] opcode,
  output acc_op_e          op,
  output logic             legal,
  output logic [CNT_W-1:0] cycles
);

  always_comb begin
    op     = OP_NONE;
    legal  = 1'b1;
    cycles = CNT_W'(CYC_SHORT);
    case (opcode)
      OPC_ASLA: op = OP_ASLA;
      OPC_ASLB: op = OP_ASLB;
      OPC_DECA: op = OP_DECA;
      OPC_DECB: op = OP_DECB;
      OPC_TBA:  op = OP_TBA;
      OPC_MUL: begin
        op     = OP_MUL;
        cycles = CNT_W'(CYC_MUL);
      end
      default: begin
        legal  = 1'b0;
        cycles = '0;
      end
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_exec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CCR_W  = 8
) (
  input  acc_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [CCR_W-1:0]  ccr,
  output logic [DATA_W-1:0] a_nxt,
  output logic [DATA_W-1:0] b_nxt,
  output logic [CCR_W-1:0]  ccr_nxt
);

  localparam int PROD_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic              use_b;
  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] shl;
  logic [DATA_W-1:0] dec;
  logic [PROD_W-1:0] prod;
  logic [DATA_W-1:0] res;

  assign use_b = (op == OP_ASLB) || (op == OP_DECB);
  assign src   = use_b ? b : a;
  assign shl   = {src[DATA_W-2:0], 1'b0};
  assign dec   = src - DATA_W'(1);
  assign prod  = PROD_W'(a) * PROD_W'(b);

  always_comb begin
    a_nxt   = a;
    b_nxt   = b;
    ccr_nxt = ccr;
    res     = src;
    case (op)
      OP_ASLA, OP_ASLB: begin
        res             = shl;
        ccr_nxt[FLAG_C] = src[DATA_W-1];
        ccr_nxt[FLAG_N] = shl[DATA_W-1];
        ccr_nxt[FLAG_Z] = ~|shl;
        ccr_nxt[FLAG_V] = shl[DATA_W-1] ^ src[DATA_W-1];
      end
      OP_DECA, OP_DECB: begin
        res             = dec;
        ccr_nxt[FLAG_N] = dec[DATA_W-1];
        ccr_nxt[FLAG_Z] = ~|dec;
        ccr_nxt[FLAG_V] = (src == MOST_NEG);
      end
      OP_TBA: begin
        ccr_nxt[FLAG_N] = b[DATA_W-1];
        ccr_nxt[FLAG_Z] = ~|b;
        ccr_nxt[FLAG_V] = 1'b0;
      end
      OP_MUL: begin
        ccr_nxt[FLAG_C] = prod[DATA_W-1];
      end
      default: ;
    endcase

    case (op)
      OP_ASLA, OP_DECA: a_nxt = res;
      OP_ASLB, OP_DECB: b_nxt = res;
      OP_TBA:           a_nxt = b;
      OP_MUL: begin
        a_nxt = prod[PROD_W-1:DATA_W];
        b_nxt = prod[DATA_W-1:0];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_seq.sv
module acc_seq #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             legal,
  input  logic [CNT_W-1:0] cycles,
  output logic             accept,
  output logic             fire,
  output logic             busy,
  output logic             done
);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q;

  assign accept = start && legal && !busy_q;
  assign fire   = busy_q && (cnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = cycles - CNT_W'(1);
    end else if (fire) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      done_q <= fire;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_exec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CCR_W  = 8,
  parameter int OPC_W  = 8,
  parameter int CNT_W  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [OPC_W-1:0]    opcode,
  input  logic [DATA_W-1:0]   acc_a_in,
  input  logic [DATA_W-1:0]   acc_b_in,
  input  logic [CCR_W-1:0]    ccr_in,
  output logic [DATA_W-1:0]   acc_a_out,
  output logic [DATA_W-1:0]   acc_b_out,
  output logic [2*DATA_W-1:0] acc_d_out,
  output logic [CCR_W-1:0]    ccr_out,
  output logic [CNT_W-1:0]    cycles_out,
  output logic                busy,
  output logic                done
);

  logic rst_sync_n;

  acc_op_e          dec_op;
  logic             dec_legal;
  logic [CNT_W-1:0] dec_cycles;

  logic accept, fire;

  acc_op_e           op_q, op_d;
  logic [DATA_W-1:0] a_cap_q, a_cap_d, b_cap_q, b_cap_d;
  logic [CCR_W-1:0]  ccr_cap_q, ccr_cap_d;

  logic [DATA_W-1:0] a_nxt, b_nxt;
  logic [CCR_W-1:0]  ccr_nxt;

  logic [DATA_W-1:0] a_q, a_d, b_q, b_d;
  logic [CCR_W-1:0]  ccr_q, ccr_d;

  acc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_sync_n)
  );

  acc_decode #(.OPC_W(OPC_W), .CNT_W(CNT_W)) u_decode (
    .opcode (opcode),
    .op     (dec_op),
    .legal  (dec_legal),
    .cycles (dec_cycles)
  );

  acc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (start),
    .legal  (dec_legal),
    .cycles (dec_cycles),
    .accept (accept),
    .fire   (fire),
    .busy   (busy),
    .done   (done)
  );

  acc_alu #(.DATA_W(DATA_W), .CCR_W(CCR_W)) u_alu (
    .op      (op_q),
    .a       (a_cap_q),
    .b       (b_cap_q),
    .ccr     (ccr_cap_q),
    .a_nxt   (a_nxt),
    .b_nxt   (b_nxt),
    .ccr_nxt (ccr_nxt)
  );

  // operand capture on acceptance
  always_comb begin
    op_d      = op_q;
    a_cap_d   = a_cap_q;
    b_cap_d   = b_cap_q;
    ccr_cap_d = ccr_cap_q;
    if (accept) begin
      op_d      = dec_op;
      a_cap_d   = acc_a_in;
      b_cap_d   = acc_b_in;
      ccr_cap_d = ccr_in;
    end
  end

  // write-back on the final cycle
  always_comb begin
    a_d   = a_q;
    b_d   = b_q;
    ccr_d = ccr_q;
    if (fire) begin
      a_d   = a_nxt;
      b_d   = b_nxt;
      ccr_d = ccr_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_q      <= OP_NONE;
      a_cap_q   <= '0;
      b_cap_q   <= '0;
      ccr_cap_q <= '0;
      a_q       <= '0;
      b_q       <= '0;
      ccr_q     <= '0;
    end else begin
      op_q      <= op_d;
      a_cap_q   <= a_cap_d;
      b_cap_q   <= b_cap_d;
      ccr_cap_q <= ccr_cap_d;
      a_q       <= a_d;
      b_q       <= b_d;
      ccr_q     <= ccr_d;
    end
  end

  assign acc_a_out  = a_q;
  assign acc_b_out  = b_q;
  assign acc_d_out  = {a_q, b_q};
  assign ccr_out    = ccr_q;
  assign cycles_out = dec_cycles;

endmodule

// File: rtl/acc_exec_chk.sv
module acc_exec_chk
  import acc_exec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CCR_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              legal,
  input logic              busy,
  input logic              done,
  input acc_op_e           op_q,
  input logic [DATA_W-1:0] a_out,
  input logic [CCR_W-1:0]  ccr_out,
  input logic [CCR_W-1:0]  ccr_cap
);

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && legal && !busy) |=> busy);

  assert_zero_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (op_q == OP_ASLA || op_q == OP_DECA || op_q == OP_TBA))
      |-> (ccr_out[FLAG_Z] == (a_out == '0)));

  assert_shift_v_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (op_q == OP_ASLA || op_q == OP_ASLB))
      |-> (ccr_out[FLAG_V] == (ccr_out[FLAG_N] ^ ccr_out[FLAG_C])));

  assert_mul_nzv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_MUL) |-> (ccr_out[3:1] == ccr_cap[3:1]));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(a_out) && $stable(ccr_out)));

  assert_busy_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(op_q));

  assert_upper_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ccr_out[CCR_W-1:4] == ccr_cap[CCR_W-1:4]));

endmodule

bind acc_exec_unit acc_exec_chk #(.DATA_W(DATA_W), .CCR_W(CCR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .start   (start),
  .legal   (dec_legal),
  .busy    (busy),
  .done    (done),
  .op_q    (op_q),
  .a_out   (acc_a_out),
  .ccr_out (ccr_out),
  .ccr_cap (ccr_cap_q)
);

// File: tb/acc_exec_unit_bench.sv
module acc_exec_unit_bench;

  typedef struct {
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] f;
    int         lat;
    int         issue;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [7:0]  a_in = 8'h00, b_in = 8'h00, f_in = 8'h00;
  logic [7:0]  a_out, b_out, f_out;
  logic [15:0] d_out;
  logic [1:0]  cyc_out;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int done_cnt = 0;
  bit monitor_on = 1'b0;
  exp_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  acc_exec_unit u_acc_exec_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .acc_a_in(a_in), .acc_b_in(b_in), .ccr_in(f_in),
    .acc_a_out(a_out), .acc_b_out(b_out), .acc_d_out(d_out),
    .ccr_out(f_out), .cycles_out(cyc_out), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // reference model written from the requirements (flags: N3 Z2 V1 C0)
  function automatic exp_t model(input logic [7:0] opc, input logic [7:0] a,
                                 input logic [7:0] b, input logic [7:0] f);
    exp_t e;
    logic [7:0] s, r;
    logic [15:0] p;
    e.a = a; e.b = b; e.f = f; e.lat = 2;
    s = (opc == 8'h58 || opc == 8'h5A) ? b : a;
    case (opc)
      8'h48, 8'h58: begin
        r = s << 1;
        e.f[0] = s[7]; e.f[3] = r[7]; e.f[2] = (r == 0); e.f[1] = r[7] ^ s[7];
        if (opc == 8'h48) e.a = r; else e.b = r;
      end
      8'h4A, 8'h5A: begin
        r = s - 8'd1;
        e.f[3] = r[7]; e.f[2] = (r == 0); e.f[1] = (s == 8'h80);
        if (opc == 8'h4A) e.a = r; else e.b = r;
      end
      8'h17: begin
        e.a = b; e.f[3] = b[7]; e.f[2] = (b == 0); e.f[1] = 1'b0;
      end
      default: begin
        p = a * b; e.a = p[15:8]; e.b = p[7:0]; e.f[0] = p[7]; e.lat = 3;
      end
    endcase
    return e;
  endfunction

  task automatic run_op(input logic [7:0] opc, input logic [7:0] a,
                        input logic [7:0] b, input logic [7:0] f, input string tag);
    exp_t e;
    @(negedge clk);
    opcode = opc; a_in = a; b_in = b; f_in = f; start = 1'b1;
    e = model(opc, a, b, f);
    e.issue = cyc + 1;
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
    while (sb.size() != 0) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (monitor_on && done) begin
      exp_t e;
      done_cnt++;
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected done actual=1 expected=0");
      end else begin
        e = sb.pop_front();
        chk(e.tag, "A", a_out, e.a);
        chk(e.tag, "B", b_out, e.b);
        chk(e.tag, "CCR", f_out, e.f);
        chk(e.tag, "D", d_out, {e.a, e.b});
        chk("R7", "latency", cyc - e.issue, e.lat);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] ha, hb, hf;
    int seen_busy;
    int dc;
    repeat (3) @(negedge clk);
    chk("R10", "busy in reset", busy, 0);
    chk("R10", "A in reset", a_out, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    monitor_on = 1'b1;
    chk("R10", "A", a_out, 0);
    chk("R10", "B", b_out, 0);
    chk("R10", "D", d_out, 0);
    chk("R10", "CCR", f_out, 0);
    chk("R10", "busy", busy, 0);
    chk("R10", "done", done, 0);

    // R11 cycle-count decode
    opcode = 8'h48; #1 chk("R11", "cycles 48", cyc_out, 2);
    opcode = 8'h5A; #1 chk("R11", "cycles 5A", cyc_out, 2);
    opcode = 8'h17; #1 chk("R11", "cycles 17", cyc_out, 2);
    opcode = 8'h3D; #1 chk("R11", "cycles 3D", cyc_out, 3);
    opcode = 8'hFF; #1 chk("R11", "cycles FF", cyc_out, 0);

    // shifts: R2, R3
    run_op(8'h48, 8'h81, 8'h33, 8'h00, "R3");
    run_op(8'h48, 8'h40, 8'h00, 8'h00, "R3");
    run_op(8'h48, 8'hC0, 8'h00, 8'h02, "R3");
    run_op(8'h48, 8'h80, 8'h12, 8'h00, "R2");
    run_op(8'h58, 8'h5A, 8'h01, 8'h0F, "R2");
    // decrements: R4
    run_op(8'h4A, 8'h80, 8'h00, 8'h00, "R4");
    run_op(8'h4A, 8'h01, 8'h00, 8'h01, "R4");
    run_op(8'h5A, 8'h77, 8'h00, 8'h01, "R4");
    run_op(8'h4A, 8'h81, 8'h00, 8'h02, "R4");
    // transfer: R5
    run_op(8'h17, 8'h55, 8'h00, 8'h03, "R5");
    run_op(8'h17, 8'h00, 8'h90, 8'h06, "R5");
    // multiply: R6
    run_op(8'h3D, 8'hFF, 8'hFF, 8'h0E, "R6");
    run_op(8'h3D, 8'h10, 8'h08, 8'h00, "R6");
    run_op(8'h3D, 8'h00, 8'h37, 8'h0B, "R6");
    // untouched bits: R9
    run_op(8'h48, 8'h01, 8'h00, 8'hF0, "R9");
    run_op(8'h3D, 8'h03, 8'h05, 8'hE5, "R9");

    // R8: second strobe while multiply runs
    dc = done_cnt;
    begin
      exp_t e;
      @(negedge clk);
      opcode = 8'h3D; a_in = 8'h0C; b_in = 8'h0B; f_in = 8'h20; start = 1'b1;
      e = model(8'h3D, 8'h0C, 8'h0B, 8'h20);
      e.issue = cyc + 1; e.tag = "R8";
      sb.push_back(e);
      @(negedge clk);
      opcode = 8'h48; a_in = 8'h99; b_in = 8'h11; f_in = 8'h00;
      @(negedge clk);
      start = 1'b0;
      repeat (8) @(negedge clk);
    end
    chk("R8", "done count", done_cnt - dc, 1);
    chk("R8", "queue drained", sb.size(), 0);

    // R1: undefined opcode starts nothing
    ha = a_out; hb = b_out; hf = f_out; dc = done_cnt; seen_busy = 0;
    @(negedge clk);
    opcode = 8'h00; a_in = 8'hAA; b_in = 8'hBB; f_in = 8'hFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) begin
      if (busy) seen_busy++;
      @(negedge clk);
    end
    chk("R1", "busy on undefined opcode", seen_busy, 0);
    chk("R1", "done count", done_cnt - dc, 0);
    chk("R1", "A kept", a_out, ha);
    chk("R1", "B kept", b_out, hb);
    chk("R1", "CCR kept", f_out, hf);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule